// File: doc/BRIEF.md
# Page Load Window Controller

This block gathers single-byte writes into a page-sized staging buffer in front of a 64K-by-8 nonvolatile array. Each accepted byte write places its data at the byte offset taken from the low address bits and records the page number taken from the high address bits. After every accepted byte, an idle counter restarts. As long as each new byte arrives before that counter runs out, the load window stays open, and it may stay open indefinitely.

When a full timeout passes with no new byte, the block hands the whole page to the array. It raises a commit request and a busy flag and holds them, with the page number and page image frozen, until the array acknowledges. The commit cannot be withdrawn once started. Byte positions that received no data in the current window are presented as FFh. After the acknowledge, the buffer forgets which bytes were loaded, so the next page starts from an all-FFh image. A command decoder gates the byte strobe through a separate enable input.

Top module: `pgl_window_ctrl`

## Requirements
- R1: Address bits 6..0 of an accepted load select the byte offset, and address bits 15..7 select the page. The byte at offset k appears on page_data_o bits [8k+7:8k], with offset 0 in the least significant byte.
- R2: Every byte offset not loaded since the last commit or reset reads as FFh on page_data_o.
- R3: A later load to an offset already loaded in the same window replaces the earlier byte.
- R4: page_addr_o equals the page bits of the most recent accepted load, even when the loads of one window target different pages.
- R5: A load is accepted when ld_valid_i and ld_en_i are high at a clock edge while busy_o is low. A load accepted on any of the IDLE_CYC edges that follow the previous accepted load restarts the idle count, and no commit starts.
- R6: If IDLE_CYC consecutive edges follow an accepted load with no new accepted load, busy_o and commit_req_o both go high at the last of those edges.
- R7: While commit_req_o is high, byte loads are ignored, and page_addr_o and page_data_o hold their values. The request stays high until commit_ack_i is seen high at a clock edge.
- R8: At the edge where commit_ack_i is high during a commit, busy_o and commit_req_o fall and all bytes revert to FFh.
- R9: A strobe with ld_en_i low is ignored: it changes no byte and opens no load window.
- R10: After reset, busy_o and commit_req_o are low, page_addr_o is zero and page_data_o is all FFh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ld_valid_i | input | 1 | Byte-write strobe, one byte per cycle |
| ld_addr_i | input | 16 | Byte address: page in bits 15..7, offset in bits 6..0 |
| ld_data_i | input | 8 | Byte to load |
| ld_en_i | input | 1 | Write permission from the command decoder |
| commit_ack_i | input | 1 | Array acknowledges the page write |
| page_addr_o | output | 9 | Page targeted by the buffer |
| page_data_o | output | 1024 | Page image, byte k in bits [8k+7:8k], unloaded bytes FFh |
| busy_o | output | 1 | Internal write in progress |
| commit_req_o | output | 1 | Request to write the page into the array |

## Verification
Two pairs of events can share a clock edge. In the first, a new byte arrives on exactly the edge where the idle count would expire. The bench waits IDLE_CYC-1 cycles after a load and then strobes the next byte, and it expects busy_o to stay low, because the load must win and restart the window. In the second, commit_ack_i arrives together with a byte strobe. The bench expects the byte to be dropped, the page to read all FFh afterwards, and busy_o to stay low through a full timeout, which proves no new window was opened.

// File: rtl/pgl_pkg.sv
`timescale 1ns/1ps
package pgl_pkg;
  typedef enum logic [1:0] {
    PGL_IDLE   = 2'd0,
    PGL_LOAD   = 2'd1,
    PGL_COMMIT = 2'd2
  } pgl_state_e;
endpackage

// File: rtl/pgl_gap_timer.sv
`timescale 1ns/1ps
module pgl_gap_timer #(
  parameter int IDLE_CYC = 40000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic restart_i,
  input  logic run_i,
  output logic expired_o
);
  localparam int CNT_W = (IDLE_CYC < 2) ? 1 : $clog2(IDLE_CYC + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(IDLE_CYC - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      cnt_q <= '0;
    else if (restart_i)               cnt_q <= '0;
    else if (run_i && cnt_q != LAST)  cnt_q <= cnt_q + 1'b1;
  end

  // a load on the expiry edge wins over the timeout
  assign expired_o = run_i && !restart_i && (cnt_q == LAST);
endmodule

// File: rtl/pgl_page_buf.sv
`timescale 1ns/1ps
module pgl_page_buf #(
  parameter int OFS_W  = 7,
  parameter int DATA_W = 8
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          wr_i,
  input  logic [OFS_W-1:0]              ofs_i,
  input  logic [DATA_W-1:0]             data_i,
  input  logic                          clr_i,
  output logic [(1<<OFS_W)*DATA_W-1:0]  page_o
);
  localparam int NB = 1 << OFS_W;

  for (genvar g = 0; g < NB; g++) begin : g_byte
    logic [DATA_W-1:0] byte_q;
    logic              vld_q;
    logic              hit;

    assign hit = wr_i && (ofs_i == OFS_W'(g));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        byte_q <= '1;
        vld_q  <= 1'b0;
      end else if (hit) begin
        byte_q <= data_i;
        vld_q  <= 1'b1;
      end else if (clr_i) begin
        vld_q  <= 1'b0;
      end
    end

    assign page_o[g*DATA_W +: DATA_W] = vld_q ? byte_q : {DATA_W{1'b1}};
  end
endmodule

// File: rtl/pgl_window_ctrl.sv
`timescale 1ns/1ps
module pgl_window_ctrl #(
  parameter int ADDR_W   = 16,
  parameter int OFS_W    = 7,
  parameter int DATA_W   = 8,
  parameter int IDLE_CYC = 40000,
  localparam int PAGE_W  = ADDR_W - OFS_W,
  localparam int PG_BITS = (1 << OFS_W) * DATA_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               ld_valid_i,
  input  logic [ADDR_W-1:0]  ld_addr_i,
  input  logic [DATA_W-1:0]  ld_data_i,
  input  logic               ld_en_i,
  input  logic               commit_ack_i,
  output logic [PAGE_W-1:0]  page_addr_o,
  output logic [PG_BITS-1:0] page_data_o,
  output logic               busy_o,
  output logic               commit_req_o
);
  import pgl_pkg::*;

  pgl_state_e state_q, state_d;
  logic       accept, expired, clr;
  logic [PAGE_W-1:0] page_q;

  assign accept = ld_valid_i && ld_en_i && (state_q != PGL_COMMIT);
  assign clr    = (state_q == PGL_COMMIT) && commit_ack_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      PGL_IDLE:   if (accept)       state_d = PGL_LOAD;
      PGL_LOAD:   if (expired)      state_d = PGL_COMMIT;
      PGL_COMMIT: if (commit_ack_i) state_d = PGL_IDLE;
      default:                      state_d = PGL_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= PGL_IDLE;
      page_q  <= '0;
    end else begin
      state_q <= state_d;
      if (accept) page_q <= ld_addr_i[ADDR_W-1:OFS_W];
    end
  end

  pgl_gap_timer #(.IDLE_CYC(IDLE_CYC)) u_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .restart_i (accept),
    .run_i     (state_q == PGL_LOAD),
    .expired_o (expired)
  );

  pgl_page_buf #(.OFS_W(OFS_W), .DATA_W(DATA_W)) u_buf (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_i   (accept),
    .ofs_i  (ld_addr_i[OFS_W-1:0]),
    .data_i (ld_data_i),
    .clr_i  (clr),
    .page_o (page_data_o)
  );

  assign page_addr_o  = page_q;
  assign busy_o       = (state_q == PGL_COMMIT);
  assign commit_req_o = (state_q == PGL_COMMIT);
endmodule

// File: rtl/pgl_window_chk.sv
`timescale 1ns/1ps
module pgl_window_chk #(
  parameter int ADDR_W   = 16,
  parameter int OFS_W    = 7,
  parameter int DATA_W   = 8,
  parameter int IDLE_CYC = 40000,
  localparam int PAGE_W  = ADDR_W - OFS_W,
  localparam int PG_BITS = (1 << OFS_W) * DATA_W,
  localparam int GAP_W   = $clog2(IDLE_CYC + 2)
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               ld_valid_i,
  input logic [ADDR_W-1:0]  ld_addr_i,
  input logic [DATA_W-1:0]  ld_data_i,
  input logic               ld_en_i,
  input logic               commit_ack_i,
  input logic [PAGE_W-1:0]  page_addr_o,
  input logic [PG_BITS-1:0] page_data_o,
  input logic               busy_o,
  input logic               commit_req_o
);
  logic             acc;
  logic             armed_q;
  logic [GAP_W-1:0] gap_q;

  assign acc = ld_valid_i && ld_en_i && !busy_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b0;
      gap_q   <= '0;
    end else if (acc) begin
      armed_q <= 1'b1;
      gap_q   <= '0;
    end else if (busy_o && commit_ack_i) begin
      armed_q <= 1'b0;
    end else if (armed_q && !busy_o) begin
      gap_q   <= gap_q + 1'b1;
    end
  end

  // R1
  byte_placed_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc |=> page_data_o[$past(ld_addr_i[OFS_W-1:0])*DATA_W +: DATA_W] == $past(ld_data_i));

  // R4
  page_follows_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc |=> page_addr_o == $past(ld_addr_i[ADDR_W-1:OFS_W]));

  // R6
  commit_timing_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> armed_q && gap_q == GAP_W'(IDLE_CYC));

  // R6
  commit_due_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed_q && !busy_o && !acc && gap_q == GAP_W'(IDLE_CYC - 1) |=> busy_o && commit_req_o);

  // R7
  commit_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_req_o && !commit_ack_i |=> commit_req_o);

  // R7
  frozen_page_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_req_o && !commit_ack_i |=> $stable(page_addr_o) && $stable(page_data_o));

  // R8
  ack_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_req_o && commit_ack_i |=> !busy_o && !commit_req_o && page_data_o == {PG_BITS{1'b1}});
endmodule

bind pgl_window_ctrl pgl_window_chk #(
  .ADDR_W(ADDR_W), .OFS_W(OFS_W), .DATA_W(DATA_W), .IDLE_CYC(IDLE_CYC)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .ld_valid_i(ld_valid_i), .ld_addr_i(ld_addr_i),
  .ld_data_i(ld_data_i), .ld_en_i(ld_en_i), .commit_ack_i(commit_ack_i),
  .page_addr_o(page_addr_o), .page_data_o(page_data_o), .busy_o(busy_o),
  .commit_req_o(commit_req_o)
);

// File: tb/pgl_window_ctrl_tb.sv
`timescale 1ns/1ps
module pgl_window_ctrl_tb;
  localparam int IDLE = 16;
  localparam int PB   = 128;
  localparam int PBW  = PB * 8;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic           rst_ni = 1'b0;
  logic           ld_valid = 1'b0, ld_en = 1'b0, ack = 1'b0;
  logic [15:0]    ld_addr = '0;
  logic [7:0]     ld_data = '0;
  logic [8:0]     page_addr;
  logic [PBW-1:0] page_data;
  logic           busy, req;

  pgl_window_ctrl #(.IDLE_CYC(IDLE)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .ld_valid_i(ld_valid), .ld_addr_i(ld_addr),
    .ld_data_i(ld_data), .ld_en_i(ld_en), .commit_ack_i(ack),
    .page_addr_o(page_addr), .page_data_o(page_data), .busy_o(busy), .commit_req_o(req)
  );

  int n_chk = 0, n_err = 0;
  bit done = 1'b0;
  logic [7:0] m_data [PB];
  bit         m_val  [PB];
  logic [8:0] m_page = '0;

  function automatic logic [PBW-1:0] exp_page();
    logic [PBW-1:0] e;
    for (int i = 0; i < PB; i++) e[i*8 +: 8] = m_val[i] ? m_data[i] : 8'hFF;
    return e;
  endfunction

  task automatic chk(string req_tag, logic [PBW-1:0] act, logic [PBW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req_tag, act, exp);
    end
  endtask

  task automatic clear_model();
    for (int i = 0; i < PB; i++) m_val[i] = 1'b0;
  endtask

  // drive at a negedge, return after the accepting edge
  task automatic load(logic [15:0] a, logic [7:0] d, bit en, bit accepted);
    ld_valid = 1'b1; ld_en = en; ld_addr = a; ld_data = d;
    @(negedge clk);
    ld_valid = 1'b0; ld_en = 1'b0;
    if (accepted) begin
      m_data[a[6:0]] = d;
      m_val[a[6:0]]  = 1'b1;
      m_page         = a[15:7];
    end
  endtask

  task automatic expect_commit();
    repeat (IDLE - 1) @(negedge clk);
    chk("R6 no early commit", PBW'(busy), PBW'(0));
    @(negedge clk);
    chk("R6 busy", PBW'(busy), PBW'(1));
    chk("R6 req", PBW'(req), PBW'(1));
    chk("R4 page", PBW'(page_addr), PBW'(m_page));
    chk("R1 R2 R3 image", page_data, exp_page());
  endtask

  task automatic finish_commit(int hold);
    logic [PBW-1:0] img;
    logic [8:0]     pg;
    img = page_data; pg = page_addr;
    for (int i = 0; i < hold; i++) begin
      load(16'($urandom), 8'($urandom), 1'b1, 1'b0);
      chk("R7 req held", PBW'(req), PBW'(1));
      chk("R7 data frozen", page_data, img);
      chk("R7 page frozen", PBW'(page_addr), PBW'(pg));
    end
    // ack together with a byte strobe
    ack = 1'b1; ld_valid = 1'b1; ld_en = 1'b1; ld_addr = 16'h0203; ld_data = 8'h11;
    @(negedge clk);
    ack = 1'b0; ld_valid = 1'b0; ld_en = 1'b0;
    clear_model();
    chk("R8 busy low", PBW'(busy), PBW'(0));
    chk("R8 req low", PBW'(req), PBW'(0));
    chk("R8 all FF", page_data, {PBW{1'b1}});
  endtask

  initial begin
    #(5.0 * 150000);
    n_err++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    clear_model();
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R10 busy", PBW'(busy), PBW'(0));
    chk("R10 req", PBW'(req), PBW'(0));
    chk("R10 page", PBW'(page_addr), PBW'(0));
    chk("R10 image", page_data, {PBW{1'b1}});

    // R9: strobe without enable
    load(16'h1234, 8'h5A, 1'b0, 1'b0);
    repeat (IDLE + 4) @(negedge clk);
    chk("R9 no window", PBW'(busy), PBW'(0));
    chk("R9 image", page_data, {PBW{1'b1}});

    // R8: dropped load at ack must not open a window (after a first commit)
    load({9'h1A5, 7'd0}, 8'h3C, 1'b1, 1'b1);
    load({9'h1A5, 7'd127}, 8'hC3, 1'b1, 1'b1);
    load({9'h1A5, 7'd5}, 8'h01, 1'b1, 1'b1);
    load({9'h1A5, 7'd5}, 8'h02, 1'b1, 1'b1);   // R3 overwrite
    expect_commit();
    finish_commit(3);
    repeat (IDLE + 2) @(negedge clk);
    chk("R8 strobe at ack dropped", PBW'(busy), PBW'(0));

    // R5: loads exactly at the timeout boundary keep the window open
    load({9'h003, 7'd9}, 8'hA1, 1'b1, 1'b1);
    for (int k = 0; k < 3; k++) begin
      repeat (IDLE - 1) @(negedge clk);
      load({9'h003, 7'(10 + k)}, 8'(8'hB0 + k), 1'b1, 1'b1);
      chk("R5 window open", PBW'(busy), PBW'(0));
    end
    expect_commit();
    finish_commit(1);

    // R4: last page wins
    load({9'h010, 7'd1}, 8'h77, 1'b1, 1'b1);
    load({9'h0FF, 7'd2}, 8'h88, 1'b1, 1'b1);
    load({9'h1C0, 7'd3}, 8'h99, 1'b1, 1'b1);
    expect_commit();
    finish_commit(2);

    // R1: full page
    for (int i = 0; i < PB; i++) load({9'h0AA, 7'(i)}, 8'(i ^ 8'h5C), 1'b1, 1'b1);
    expect_commit();
    finish_commit(0);

    // random windows
    for (int r = 0; r < 14; r++) begin
      int n;
      n = 1 + int'($urandom % 12);
      for (int b = 0; b < n; b++) begin
        load(16'($urandom), 8'($urandom), 1'b1, 1'b1);
        if (b != n - 1) repeat (int'($urandom % IDLE)) @(negedge clk);
      end
      expect_commit();
      finish_commit(int'($urandom % 4));
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule